// File: doc/BRIEF.md
# UART Interrupt Status, Mask and Line Router

This block gathers the interrupt events of a serial port into one sticky status word and drives six interrupt lines from it. The datapath raises events by pulsing bits of `evt_set`. Each pulse sets the matching bit of the raw status, and that bit stays set until software clears it. Software reaches the block through a small register port addressed by word offset. It can program an enable mask, read the raw and the masked status, clear bits by writing ones, and write transmit data. Every transmit data write raises the transmit event.

The five group lines carry receive, transmit, receive timeout, modem status and error. A sixth line is the OR of all enabled sources. Software can wire only the combined line to its interrupt controller, or it can route the group lines separately. The lines are registered, so they lag a status or mask change by exactly one clock.

Status bit layout: bit 0 receive, bit 1 transmit, bit 2 receive timeout, bits 3 to 6 modem status (ring, carrier detect, clear-to-send, set-ready), bits 7 to 10 errors (framing, parity, break, overrun).

Top module: `uart_irq_router`

## Requirements
- R1: A synchronous reset (`rst` high) clears the mask and the raw status. It also drives all six interrupt lines low.
- R2: Offset 0 is the mask register. A write loads `wdata[10:0]` on the next edge, and a read returns the mask zero-extended.
- R3: Offset 1 reads the raw status. A 1 on `evt_set[i]` in a cycle sets raw bit i at the following edge, and the bit stays set until it is cleared.
- R4: Offset 2 reads the masked status, which is the raw status ANDed with the mask.
- R5: A write to offset 3 clears each raw bit whose `wdata` bit is 1 and leaves the other bits as they were. A read of offset 3 returns 0.
- R6: A write to offset 1 or 2, or to an unmapped offset (5 to 7), changes neither the mask nor the raw status. A read of an unmapped offset returns 0.
- R7: A write to offset 4 (transmit data) sets raw bit 1, whatever the data value. A read of offset 4 returns 0.
- R8: If an event sets a bit in the same cycle that a clear write clears it, the bit ends up set.
- R9: `irq_rx`, `irq_tx` and `irq_rto` follow masked bits 0, 1 and 2. `irq_modem` is the OR of masked bits 3 to 6, `irq_err` is the OR of masked bits 7 to 10, and `irq_all` is the OR of all masked bits.
- R10: Each interrupt line is a register. It shows the masked status as it stood one clock earlier. `rdata` is a combinational read of the current registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 3 | Register word offset |
| wr_en | input | 1 | Write strobe for the offset on `addr` |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the offset on `addr` |
| evt_set | input | 11 | Per-source event pulses from the datapath |
| irq_all | output | 1 | OR of all enabled sources |
| irq_rx | output | 1 | Receive line |
| irq_tx | output | 1 | Transmit line |
| irq_rto | output | 1 | Receive timeout line |
| irq_modem | output | 1 | Modem status group line |
| irq_err | output | 1 | Error group line |

## Verification
A corrupted raw or mask bit shows on the next read of offset 1, 2 or 0. It reaches the interrupt lines one clock after the corruption, and it persists because the status is sticky. A wrong group mapping shows up when a single modem or error bit is raised and the wrong line responds. A lost set-over-clear priority shows as a bit that reads 0 after a collision. Each step compares the read data and all six lines with a bench model, so a divergence is reported within one clock of its cause.

// File: rtl/uirq_pkg.sv
`timescale 1ns/1ps
package uirq_pkg;
  localparam int NUM_SRC   = 11;
  localparam int NUM_LINES = 6;
  localparam int BIT_TX    = 1;

  typedef logic [NUM_SRC-1:0] src_t;

  typedef enum logic [2:0] {
    OFS_MASK   = 3'd0,
    OFS_RAW    = 3'd1,
    OFS_MASKED = 3'd2,
    OFS_CLEAR  = 3'd3,
    OFS_TXDATA = 3'd4
  } ofs_e;

  // source set covered by each output line: 0 all, 1 rx, 2 tx, 3 timeout, 4 modem, 5 error
  function automatic src_t group_mask(input int line);
    case (line)
      0:       return '1;
      1:       return src_t'(11'h001);
      2:       return src_t'(11'h002);
      3:       return src_t'(11'h004);
      4:       return src_t'(11'h078);
      default: return src_t'(11'h780);
    endcase
  endfunction

  function automatic logic group_hit(input src_t masked, input src_t grp);
    return |(masked & grp);
  endfunction

  function automatic src_t next_raw(input src_t raw, input src_t clr, input src_t set);
    return (raw & ~clr) | set;
  endfunction
endpackage

// File: rtl/uirq_decode.sv
`timescale 1ns/1ps
module uirq_decode
  import uirq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic              wr_mask,
  output logic              wr_clear,
  output logic              wr_tx,
  output logic              wr_ignored
);
  always_comb begin
    wr_mask    = wr_en && (addr == ADDR_W'(OFS_MASK));
    wr_clear   = wr_en && (addr == ADDR_W'(OFS_CLEAR));
    wr_tx      = wr_en && (addr == ADDR_W'(OFS_TXDATA));
    wr_ignored = wr_en && !wr_mask && !wr_clear && !wr_tx;
  end
endmodule

// File: rtl/uirq_status.sv
`timescale 1ns/1ps
module uirq_status
  import uirq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_mask,
  input  logic wr_clear,
  input  logic wr_tx,
  input  src_t wdata_src,
  input  src_t evt_set,
  output src_t raw_q,
  output src_t mask_q,
  output src_t masked
);
  src_t clr_vec;
  src_t set_vec;

  always_comb begin
    clr_vec = wr_clear ? wdata_src : '0;
    set_vec = evt_set | (wr_tx ? src_t'(1 << BIT_TX) : '0);
    masked  = raw_q & mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= next_raw(raw_q, clr_vec, set_vec);
      if (wr_mask) mask_q <= wdata_src;
    end
  end

  assert_mask_load_R2: assert property (@(posedge clk) disable iff (rst)
    wr_mask |=> (mask_q == $past(wdata_src)));

  assert_event_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (|evt_set) |=> ((raw_q & $past(evt_set)) == $past(evt_set)));

  assert_clear_hits_R5: assert property (@(posedge clk) disable iff (rst)
    wr_clear |=> ((raw_q & $past(wdata_src & ~evt_set)) == '0));

  assert_tx_write_R7: assert property (@(posedge clk) disable iff (rst)
    wr_tx |=> raw_q[BIT_TX]);

  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_clear && |(wdata_src & evt_set)) |=> ((raw_q & $past(wdata_src & evt_set)) != '0));
endmodule

// File: rtl/uirq_route.sv
`timescale 1ns/1ps
module uirq_route
  import uirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  src_t                 masked,
  output logic [NUM_LINES-1:0] lines_q
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) lines_q[g] <= 1'b0;
      else     lines_q[g] <= group_hit(masked, group_mask(g));
    end
  end

  assert_combined_lag_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lines_q[0] == $past(|masked)));

  assert_group_subset_R9: assert property (@(posedge clk) disable iff (rst)
    (|lines_q[NUM_LINES-1:1]) |-> lines_q[0]);
endmodule

// File: rtl/uart_irq_router.sv
`timescale 1ns/1ps
module uart_irq_router
  import uirq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NUM_SRC-1:0] evt_set,
  output logic              irq_all,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_rto,
  output logic              irq_modem,
  output logic              irq_err
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic wr_mask, wr_clear, wr_tx, wr_ignored;
  src_t raw_q, mask_q, masked, wdata_src;
  logic [NUM_LINES-1:0] lines_q;
  logic unused_wdata_hi;

  assign wdata_src       = wdata[NUM_SRC-1:0];
  assign unused_wdata_hi = ^wdata[DATA_W-1:NUM_SRC];

  uirq_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr(addr), .wr_en(wr_en), .wr_mask(wr_mask), .wr_clear(wr_clear),
    .wr_tx(wr_tx), .wr_ignored(wr_ignored)
  );

  uirq_status i_status (
    .clk(clk), .rst(rst), .wr_mask(wr_mask), .wr_clear(wr_clear), .wr_tx(wr_tx),
    .wdata_src(wdata_src), .evt_set(evt_set), .raw_q(raw_q), .mask_q(mask_q),
    .masked(masked)
  );

  uirq_route i_route (
    .clk(clk), .rst(rst), .masked(masked), .lines_q(lines_q)
  );

  always_comb begin
    case (addr)
      ADDR_W'(OFS_MASK):   rdata = {{PAD_W{1'b0}}, mask_q};
      ADDR_W'(OFS_RAW):    rdata = {{PAD_W{1'b0}}, raw_q};
      ADDR_W'(OFS_MASKED): rdata = {{PAD_W{1'b0}}, masked};
      default:             rdata = '0;
    endcase
  end

  assign irq_all   = lines_q[0];
  assign irq_rx    = lines_q[1];
  assign irq_tx    = lines_q[2];
  assign irq_rto   = lines_q[3];
  assign irq_modem = lines_q[4];
  assign irq_err   = lines_q[5];

  assert_ignored_write_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_ignored && evt_set == '0) |=> ($stable(raw_q) && $stable(mask_q)));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (lines_q == '0 && raw_q == '0 && mask_q == '0));
endmodule

// File: tb/test_uart_irq_router.sv
`timescale 1ns/1ps
module test_uart_irq_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [10:0] evt_set = '0;
  logic irq_all, irq_rx, irq_tx, irq_rto, irq_modem, irq_err;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  logic [10:0] m_raw = '0, m_mask = '0;
  logic [5:0]  m_lines = '0;

  always #2.5 clk = ~clk;

  uart_irq_router i_uart_irq_router (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .evt_set(evt_set), .irq_all(irq_all), .irq_rx(irq_rx), .irq_tx(irq_tx),
    .irq_rto(irq_rto), .irq_modem(irq_modem), .irq_err(irq_err)
  );

  // lines as {err, modem, rto, tx, rx, all}
  function automatic logic [5:0] f_lines(input logic [10:0] r, input logic [10:0] m);
    logic [10:0] v = r & m;
    return {|v[10:7], |v[6:3], v[2], v[1], v[0], |v};
  endfunction

  function automatic logic [31:0] f_read(input logic [2:0] a);
    case (a)
      3'd0:    return {21'd0, m_mask};
      3'd1:    return {21'd0, m_raw};
      3'd2:    return {21'd0, m_raw & m_mask};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string f_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  endtask

  // drive one cycle, check outputs of the previous edge, then advance the model
  task automatic step(input logic [2:0] a, input logic w, input logic [31:0] d,
                      input logic [10:0] s, input string ltag);
    logic [10:0] clr, txb;
    @(negedge clk);
    addr = a; wr_en = w; wdata = d; evt_set = s;
    #1;
    check(f_tag(a), rdata, f_read(a));
    check(ltag, {26'd0, irq_err, irq_modem, irq_rto, irq_tx, irq_rx, irq_all},
          {26'd0, m_lines});
    clr = (w && a == 3'd3) ? d[10:0] : 11'd0;
    txb = (w && a == 3'd4) ? 11'h002 : 11'd0;
    m_lines = f_lines(m_raw, m_mask);
    m_raw   = (m_raw & ~clr) | s | txb;
    if (w && a == 3'd0) m_mask = d[10:0];
  endtask

  initial begin
    #(5.0 * 150000);
    n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    check("R1", {26'd0, irq_err, irq_modem, irq_rto, irq_tx, irq_rx, irq_all}, 32'd0);
    step(3'd0, 1'b0, 0, 0, "R1");
    step(3'd1, 1'b0, 0, 0, "R1");
    // R2: mask write and readback
    step(3'd0, 1'b1, 32'hFFFF_F7FF, 0, "R9");
    step(3'd0, 1'b0, 0, 0, "R9");
    // R3/R9: one modem bit (clear-to-send, bit 5)
    step(3'd2, 1'b0, 0, 11'h020, "R9");
    step(3'd2, 1'b0, 0, 0, "R9");
    step(3'd1, 1'b0, 0, 0, "R10");
    // R8: clear and set of bit 5 collide
    step(3'd3, 1'b1, 32'h020, 11'h020, "R9");
    step(3'd1, 1'b0, 0, 0, "R8");
    check("R8", rdata, 32'h020);
    // R5: plain clear
    step(3'd3, 1'b1, 32'h020, 0, "R9");
    step(3'd1, 1'b0, 0, 0, "R5");
    // R6: writes to raw, masked and unmapped offsets are dropped
    step(3'd1, 1'b1, 32'h7FF, 0, "R6");
    step(3'd2, 1'b1, 32'h7FF, 0, "R6");
    step(3'd6, 1'b1, 32'h7FF, 0, "R6");
    step(3'd1, 1'b0, 0, 0, "R6");
    check("R6", rdata, 32'd0);
    // R7: transmit write with zero data
    step(3'd4, 1'b1, 32'h0, 0, "R9");
    step(3'd1, 1'b0, 0, 0, "R7");
    check("R7", rdata, 32'h002);
    // error group: parity bit 8
    step(3'd0, 1'b0, 0, 11'h100, "R9");
    step(3'd0, 1'b0, 0, 0, "R9");
    // R10: masking off drops the lines one cycle later
    step(3'd0, 1'b1, 32'h0, 0, "R10");
    step(3'd2, 1'b0, 0, 0, "R10");
    step(3'd2, 1'b0, 0, 0, "R10");
    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [2:0]  a = 3'($urandom % 8);
      logic        w = ($urandom % 3) == 0;
      logic [31:0] d = $urandom;
      logic [10:0] s = (($urandom % 4) == 0) ? 11'($urandom) : 11'd0;
      step(a, w, d, s, "R9_R10");
    end
    for (int i = 0; i < 4; i++) step(3'd2, 1'b0, 0, 0, "R9_R10");
    finish_run();
  end
endmodule